// File: doc/BRIEF.md
# Two-Wire Bus Target with Transfer Status Flags

This block is the target (slave) side of a two-wire serial bus with one programmable 7-bit address. SCL and SDA are brought into the system clock domain through a synchroniser and oversampled. The system clock must run at least eight times faster than SCL. The block detects START, repeated START and STOP conditions and decodes the address byte. It then either receives bytes from the bus master or sends bytes to it. The pads stay outside the block: the block drives two pull-low enables and reads back the two wired line levels.

When sending, bytes come from a single-entry holding register. A transmit-request output tells a data mover (for example a DMA channel) that the holding register can take another byte. If the next byte is needed and the holding register is empty, the block pulls SCL low until the byte is written. A byte budget, loaded when the read address matches, limits how many bytes are taken from the holding register in one transfer.

A seven-bit sticky status vector records how each transfer ended. Software clears its bits by writing ones. An interrupt output is the OR of the status bits that the enable mask selects.

Top module: `tw_target`

## Requirements
- R1: After synchronous reset, the status vector is all zero, both pull-low enables are off, the interrupt is low and the transmit request is low.
- R2: The address byte after a START is acknowledged (SDA pulled low on its ninth clock) only when its upper seven bits equal `own_addr`. On a mismatch the block drives nothing, sets no status bit and ignores the bus until the next START.
- R3: After a matching address, bit 0 of status (direction) is set to 1 when the address byte's LSB is 1 (target sends) and cleared when it is 0 (target receives).
- R4: In send mode each byte is taken from the holding register and shifted out MSB first. `tx_req` is high during the send phase while the holding register is empty and the byte budget is non-zero.
- R5: On the ninth clock of a sent byte the block releases SDA and samples it. High sets status bit 1 (no-acknowledge) and the block sends nothing more in that transfer. Low clears bit 1, sets bit 2 (byte finished) and starts the next byte.
- R6: In receive mode every byte is acknowledged, latched onto `rxd` and flagged by status bit 6 (receive ready).
- R7: A STOP after a matching address sets status bit 4 (stop) and bit 5 (transfer complete).
- R8: When a byte must be sent, the budget is non-zero and the holding register is empty, the block pulls SCL low with SDA released until `tx_wr` arrives.
- R9: A START seen after a matching address sets status bit 3 (repeated start) and restarts address decoding.
- R10: Status bits stay set until a 1 is written to the same bit of `stat_clr`; a set event in the same cycle wins. `irq` is high one cycle after any status bit is set while the same bit of `irq_en` is 1.
- R11: `byte_count` is captured when a read address matches. Once that many bytes have been taken, further requested bytes are sent as 0xFF and `tx_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Wired SCL line level |
| sda_i | input | 1 | Wired SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Target address |
| byte_count | input | 8 | Byte budget for a read transfer |
| txd | input | 8 | Byte for the holding register |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_req | output | 1 | Holding register may be written (data mover request) |
| rxd | output | 8 | Last received byte |
| status | output | 7 | Sticky flags: 0 direction, 1 no-ack, 2 byte finished, 3 repeated start, 4 stop, 5 complete, 6 receive ready |
| stat_clr | input | 7 | Write-one-to-clear strobes for status |
| irq_en | input | 7 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks several rules on every cycle. SCL is held low only while a byte is being requested, and SDA is released during that hold. A stop flag never appears without the complete flag. The stop and repeated-start flags fall only after a clear strobe. A fully masked interrupt stays low. The bench scenarios show the rest, because each needs a whole bus transaction: the address match and mismatch, byte order on the wire, the acknowledge handling, the received-data path, the byte budget falling back to 0xFF, and the final flag pattern of each transfer.

// File: rtl/tw_target_pkg.sv
package tw_target_pkg;
  localparam int NFLAG   = 7;
  localparam int F_DIR   = 0;
  localparam int F_NACK  = 1;
  localparam int F_BFIN  = 2;
  localparam int F_RSTA  = 3;
  localparam int F_STOP  = 4;
  localparam int F_DONE  = 5;
  localparam int F_RXRDY = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK,
    ST_TX, ST_TACK, ST_WAIT, ST_DONE
  } tw_state_e;
endpackage

// File: rtl/tw_target_sync.sv
module tw_target_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign lvl_o  = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall_o = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/tw_target_fsm.sv
module tw_target_fsm
  import tw_target_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_h,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_h,
  input  logic             sda_rise,
  input  logic             sda_fall,
  input  logic [AW-1:0]    own_addr,
  input  logic [CW-1:0]    byte_count,
  input  logic [DW-1:0]    txd,
  input  logic             tx_wr,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic [DW-1:0]    rxd,
  output logic             tx_req,
  output logic [NFLAG-1:0] flag_set,
  output logic [NFLAG-1:0] flag_hwclr
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);
  localparam logic [BCW-1:0] FULL_CNT = BCW'(DW);

  tw_state_e      state;
  logic [BCW-1:0] cnt;
  logic [DW-1:0]  sh;
  logic [DW-1:0]  hold;
  logic           full;
  logic [CW-1:0]  rem;
  logic           dir;
  logic           nak_q;
  logic           start_c, stop_c, active, feed_now;

  assign start_c = sda_fall & scl_h;
  assign stop_c  = sda_rise & scl_h;
  assign active  = (state != ST_IDLE) && (state != ST_ADDR);

  always_comb begin
    feed_now = 1'b0;
    if (!start_c && !stop_c && scl_fall) begin
      if (state == ST_AACK && dir)    feed_now = 1'b1;
      if (state == ST_TACK && !nak_q) feed_now = 1'b1;
    end
  end

  assign tx_req = dir && !full && (rem != '0) &&
                  (state == ST_AACK || state == ST_TX ||
                   state == ST_TACK || state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      hold       <= '0;
      full       <= 1'b0;
      rem        <= '0;
      dir        <= 1'b0;
      nak_q      <= 1'b0;
      sda_oe     <= 1'b0;
      scl_oe     <= 1'b0;
      rxd        <= '0;
      flag_set   <= '0;
      flag_hwclr <= '0;
    end else begin
      flag_set   <= '0;
      flag_hwclr <= '0;
      if (start_c) begin
        if (active) flag_set[F_RSTA] <= 1'b1;
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_c) begin
        if (active) begin
          flag_set[F_STOP] <= 1'b1;
          flag_set[F_DONE] <= 1'b1;
        end
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_h};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL_CNT) begin
              if (sh[DW-1:1] == own_addr) begin
                dir    <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
                if (sh[0]) begin
                  flag_set[F_DIR] <= 1'b1;
                  rem             <= byte_count;
                end else begin
                  flag_hwclr[F_DIR] <= 1'b1;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (!dir) begin
                state <= ST_RX;
                cnt   <= '0;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_h};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL_CNT) begin
              rxd                <= sh;
              flag_set[F_RXRDY]  <= 1'b1;
              sda_oe             <= 1'b1;
              state              <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_TACK;
              end else begin
                sda_oe <= ~sh[DW-2];
                sh     <= {sh[DW-2:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              nak_q <= sda_h;
            end else if (scl_fall) begin
              if (nak_q) begin
                flag_set[F_NACK] <= 1'b1;
                state            <= ST_DONE;
              end else begin
                flag_hwclr[F_NACK] <= 1'b1;
                flag_set[F_BFIN]   <= 1'b1;
              end
            end
          end
          ST_WAIT: begin
            if (full) begin
              sh     <= hold;
              sda_oe <= ~hold[DW-1];
              full   <= 1'b0;
              rem    <= rem - 1'b1;
              scl_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_TX;
            end
          end
          default: ;
        endcase
        if (feed_now) begin
          cnt <= '0;
          if (rem == '0) begin
            sh     <= '1;
            sda_oe <= 1'b0;
            state  <= ST_TX;
          end else if (full) begin
            sh     <= hold;
            sda_oe <= ~hold[DW-1];
            full   <= 1'b0;
            rem    <= rem - 1'b1;
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            scl_oe <= 1'b1;
            state  <= ST_WAIT;
          end
        end
      end
      if (tx_wr) begin
        hold <= txd;
        full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tw_target_flags.sv
module tw_target_flags #(
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] hw_set,
  input  logic [NF-1:0] hw_clr,
  input  logic [NF-1:0] sw_clr,
  input  logic [NF-1:0] irq_en,
  output logic [NF-1:0] status,
  output logic          irq
);
  logic [NF-1:0] nxt;

  assign nxt = (status & ~(sw_clr | hw_clr)) | hw_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |(nxt & irq_en);
    end
  end
endmodule

// File: rtl/tw_target.sv
module tw_target
  import tw_target_pkg::*;
#(
  parameter int AW      = 7,
  parameter int DW      = 8,
  parameter int CW      = 8,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic [AW-1:0]    own_addr,
  input  logic [CW-1:0]    byte_count,
  input  logic [DW-1:0]    txd,
  input  logic             tx_wr,
  output logic             tx_req,
  output logic [DW-1:0]    rxd,
  output logic [NFLAG-1:0] status,
  input  logic [NFLAG-1:0] stat_clr,
  input  logic [NFLAG-1:0] irq_en,
  output logic             irq
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw, lvl, rise, fall;
  logic [NFLAG-1:0] fset, fclr;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_sync
    tw_target_sync #(.STAGES(SYNC_FF)) u_sync (
      .clk(clk), .rst(rst), .line_i(raw[g]),
      .lvl_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  tw_target_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_h(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_h(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .own_addr(own_addr), .byte_count(byte_count),
    .txd(txd), .tx_wr(tx_wr),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .rxd(rxd), .tx_req(tx_req),
    .flag_set(fset), .flag_hwclr(fclr)
  );

  tw_target_flags #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .hw_set(fset), .hw_clr(fclr),
    .sw_clr(stat_clr), .irq_en(irq_en), .status(status), .irq(irq)
  );
endmodule

// File: rtl/tw_target_chk.sv
module tw_target_chk
  import tw_target_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             tx_req,
  input logic [NFLAG-1:0] status,
  input logic [NFLAG-1:0] stat_clr,
  input logic [NFLAG-1:0] irq_en,
  input logic             irq
);
  AST_HOLD_ONLY_FOR_DATA: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> (tx_req || $past(tx_req))); // R8
  AST_HOLD_SDA_FREE: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !sda_oe); // R8
  AST_STOP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(status[F_STOP]) |-> status[F_DONE]); // R7
  AST_STOP_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(status[F_STOP]) |-> $past(stat_clr[F_STOP])); // R10
  AST_RSTA_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(status[F_RSTA]) |-> $past(stat_clr[F_RSTA])); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq); // R10
endmodule

bind tw_target tw_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_req(tx_req),
  .status(status), .stat_clr(stat_clr), .irq_en(irq_en), .irq(irq)
);

// File: tb/tw_target_bench.sv
module tw_target_bench;
  import tw_target_pkg::*;
  localparam int T = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_w, sda_w, scl_oe, sda_oe, tx_req, tx_wr, irq;
  logic [6:0] own_addr = 7'h2C;
  logic [7:0] byte_count = 8'd3, txd, rxd;
  logic [NFLAG-1:0] status, clr_t, irq_en, stat_clr;
  logic rx_clr = 1'b0;
  logic stretch_seen = 1'b0;
  int n_cmp = 0, n_bad = 0, feed_delay = 0, feed_wait = 0;
  logic [7:0] rx_q[$];
  logic [7:0] feed_q[$];

  assign scl_w = scl_m & ~scl_oe;
  assign sda_w = sda_m & ~sda_oe;
  assign stat_clr = clr_t | {rx_clr, 6'b0};

  tw_target u_tw_target (
    .clk(clk), .rst(rst), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
    .byte_count(byte_count), .txd(txd), .tx_wr(tx_wr), .tx_req(tx_req),
    .rxd(rxd), .status(status), .stat_clr(stat_clr), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl();
    wt(1);
    while (!scl_w) wt(1);
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; wt(T); scl_m = 1'b1; wait_scl(); wt(T); scl_m = 1'b0; wt(2);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wt(T); scl_m = 1'b1; wait_scl(); wt(T/2);
    b = sda_w; wt(T/2); scl_m = 1'b0; wt(2);
  endtask

  task automatic byte_w(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(nak);
  endtask

  task automatic byte_r(output logic [7:0] d, input logic nak);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(nak);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wt(T); scl_m = 1'b1; wait_scl();
    end
    wt(T); sda_m = 1'b0; wt(T); scl_m = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(T); scl_m = 1'b1; wait_scl(); wt(T); sda_m = 1'b1; wt(T);
  endtask

  task automatic clr_flags(input logic [6:0] m);
    clr_t = m; wt(1); clr_t = '0; wt(3);
  endtask

  // monitor: received bytes against scoreboard queue (R6)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && status[F_RXRDY] && !rx_clr) begin
        if (rx_q.size() == 0) chk("R6 unexpected byte", {24'd0, rxd}, 32'hFFFF);
        else chk("R6 rx byte", {24'd0, rxd}, {24'd0, rx_q.pop_front()});
        rx_clr = 1'b1;
      end else begin
        rx_clr = 1'b0;
      end
    end
  end

  // data mover model answering tx_req
  initial begin
    tx_wr = 1'b0; txd = '0;
    forever begin
      @(negedge clk);
      tx_wr = 1'b0;
      if (!rst && tx_req && feed_q.size() > 0) begin
        if (feed_wait < feed_delay) feed_wait++;
        else begin
          txd = feed_q.pop_front(); tx_wr = 1'b1;
          feed_wait = 0; feed_delay = 0;
        end
      end
    end
  end

  always @(posedge clk) if (scl_oe) stretch_seen <= 1'b1;

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    clr_t = '0; irq_en = '0;
    wt(5); rst = 1'b0; wt(4);
    chk("R1 reset outputs", {20'd0, status, scl_oe, sda_oe, irq, tx_req}, 32'd0);
    irq_en = 7'b1 << F_STOP;

    // write transfer
    bus_start(); byte_w({7'h2C, 1'b0}, a);
    chk("R2 address ack", {31'd0, a}, 32'd0);
    chk("R3 direction receive", {31'd0, status[F_DIR]}, 32'd0);
    rx_q.push_back(8'hA5); byte_w(8'hA5, a);
    chk("R6 data ack", {31'd0, a}, 32'd0);
    rx_q.push_back(8'h3C); byte_w(8'h3C, a);
    bus_stop(); wt(10);
    chk("R7 stop flags", {26'd0, status[5:0]}, 32'h30);
    chk("R10 irq on enabled flag", {31'd0, irq}, 32'd1);
    chk("R6 all bytes seen", rx_q.size(), 32'd0);
    clr_flags(7'h7F);
    chk("R10 cleared", {24'd0, status, irq}, 32'd0);

    // foreign address
    bus_start(); byte_w({7'h33, 1'b0}, a);
    chk("R2 mismatch nack", {31'd0, a}, 32'd1);
    byte_w(8'h55, a);
    chk("R2 data ignored", {31'd0, a}, 32'd1);
    bus_stop(); wt(10);
    chk("R2 no flags", {25'd0, status}, 32'd0);

    // read transfer with late first byte
    feed_q.push_back(8'h81); feed_q.push_back(8'h7E); feed_q.push_back(8'hC3);
    feed_delay = 300;
    bus_start(); byte_w({7'h2C, 1'b1}, a);
    chk("R2 read address ack", {31'd0, a}, 32'd0);
    byte_r(d, 1'b0);
    chk("R4 byte0", {24'd0, d}, 32'h81);
    chk("R8 scl held", {31'd0, stretch_seen}, 32'd1);
    byte_r(d, 1'b0);
    chk("R4 byte1", {24'd0, d}, 32'h7E);
    wt(5);
    chk("R5 ack flags", {30'd0, status[F_BFIN], status[F_NACK]}, 32'h2);
    byte_r(d, 1'b1);
    chk("R4 byte2", {24'd0, d}, 32'hC3);
    bus_stop(); wt(10);
    chk("R5 nack end flags", {26'd0, status[5:0]}, 32'h37);
    chk("R4 all fed", feed_q.size(), 32'd0);
    clr_flags(7'h7F);

    // byte budget
    byte_count = 8'd1;
    feed_q.push_back(8'h5B);
    bus_start(); byte_w({7'h2C, 1'b1}, a);
    byte_r(d, 1'b0);
    chk("R4 budget byte", {24'd0, d}, 32'h5B);
    feed_q.push_back(8'hE7);
    byte_r(d, 1'b1);
    chk("R11 filler byte", {24'd0, d}, 32'hFF);
    bus_stop(); wt(10);
    chk("R11 no request", feed_q.size(), 32'd1);
    feed_q.delete();
    clr_flags(7'h7F);
    byte_count = 8'd3;

    // repeated start: write then read
    bus_start(); byte_w({7'h2C, 1'b0}, a);
    rx_q.push_back(8'h11); byte_w(8'h11, a);
    bus_start(); byte_w({7'h2C, 1'b1}, a);
    chk("R9 readdress ack", {31'd0, a}, 32'd0);
    feed_q.push_back(8'h99);
    byte_r(d, 1'b1);
    chk("R9 byte after restart", {24'd0, d}, 32'h99);
    bus_stop(); wt(10);
    chk("R9 flags", {26'd0, status[5:0]}, 32'h3B);
    chk("R6 restart byte seen", rx_q.size(), 32'd0);

    // partial clear and interrupt mask
    clr_flags(7'b1 << F_STOP);
    chk("R10 partial clear", {26'd0, status[5:0]}, 32'h2B);
    chk("R10 irq masked source cleared", {31'd0, irq}, 32'd0);
    irq_en = 7'b1 << F_DONE; wt(3);
    chk("R10 irq other source", {31'd0, irq}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule